// File: doc/BRIEF.md
# Indirectly Selected Vectored Interrupt Controller

This block gathers up to 128 raw interrupt inputs and turns them into one vectored normal request line and one fast request line for a processor core. Every source has its own trigger type, 3-bit priority, vector word, enable bit and fast-routing bit. Software never addresses this per-source state through an array of registers. It first writes a source number into a select register. Each later mode, vector, enable, disable, clear, set or fast-routing access then applies to that one source.

Among pending, enabled sources that are not routed to the fast line, the controller picks the one with the highest priority. A read of the vector register acknowledges that winner. The read pushes the winner's priority and number onto an 8-level nesting stack. An end-of-interrupt write pops the stack. The normal request line only asks for a new interrupt when some candidate has a priority strictly above the one currently being serviced. Source 0, and any source switched to fast routing, drives the fast line instead.

Top module: `isel_vic`

## Requirements
- R1: Writing byte offset 0x00 stores the low 7 bits of the write data as the selected source number, and a read of 0x00 returns it. Mode, vector, command and fast-routing accesses touch only the selected source.
- R2: Offset 0x04 holds the selected source's priority in bits [2:0] and its trigger type in bits [6:5], with 0 = low level, 1 = falling edge, 2 = high level and 3 = rising edge. After reset every source is type 2 with priority 0. An edge type ignores the opposite edge.
- R3: Offset 0x08 holds a 32-bit vector for the selected source and reads it back.
- R4: A read of 0x10 returns the vector of the arbitration winner when that winner may be taken. Otherwise it returns the spurious value written at offset 0x3c.
- R5: The winner is the candidate with the highest priority. Among candidates of equal priority, the lowest source number wins.
- R6: Writing bit 0 = 1 to 0x40, 0x44, 0x48 or 0x4c enables, disables, clears the pending latch of, or sets pending on, the selected source. Bit 0 of a read of 0x30 shows the selected source's enable bit.
- R7: An edge source latches pending on its edge, and the latch clears when its vector is read. A level source's pending bit follows its input. Reads of 0x20, 0x24, 0x28 and 0x2c return pending bits, with bit j of word k standing for source 32k+j.
- R8: A taken vector read pushes the winner onto the nesting stack. The registered output irq_o is high only while a candidate's priority is strictly above the stack top, or while the stack is empty and any candidate exists.
- R9: A read of 0x18 returns the source number at the stack top, or 0 when the stack is empty. A write to 0x38 pops one level, so eight such writes empty a full stack, and a pop on an empty stack changes nothing.
- R10: Source 0, and any source whose fast-routing bit is set, drives fiq_o and never takes part in IRQ arbitration. Writing bit 0 = 1 to 0x50 sets the selected source's fast-routing bit, writing it to 0x54 clears it, and bit 0 of a read of 0x58 reports it.
- R11: A read of 0x34 returns fiq_o in bit 0 and irq_o in bit 1.
- R12: After reset both request outputs are low, no source is enabled or latched, and the stack is empty. Read data appears on bus_rdata on the cycle after the bus_rd strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| src_i | input | 128 | Raw interrupt source inputs |
| irq_o | output | 1 | Normal interrupt request, active high |
| fiq_o | output | 1 | Fast interrupt request, active high |

## Verification
The bench uses the default parameters: 128 sources, 3-bit priority, 32-bit vectors and an 8-deep nesting stack. These values put source 127 in bit 31 of the last pending word, so the wrap of the select field and the top word decode are both tested. They also make one push per priority level fill the stack exactly, and the bench then unwinds it with eight end-of-interrupt writes plus one extra. Nesting, equal-priority ties, blocking by an equal priority on the stack, and fast-routing diversion are all checked against expected vectors and identifiers.

// File: rtl/isel_vic_pkg.sv
package isel_vic_pkg;

  typedef enum logic [1:0] {
    TRIG_LOW  = 2'd0,
    TRIG_FALL = 2'd1,
    TRIG_HIGH = 2'd2,
    TRIG_RISE = 2'd3
  } trig_e;

  localparam logic [7:0] OFS_SEL   = 8'h00;
  localparam logic [7:0] OFS_MODE  = 8'h04;
  localparam logic [7:0] OFS_VEC   = 8'h08;
  localparam logic [7:0] OFS_IVR   = 8'h10;
  localparam logic [7:0] OFS_ISR   = 8'h18;
  localparam logic [3:0] OFS_PEND_HI = 4'h2;
  localparam logic [7:0] OFS_MASK  = 8'h30;
  localparam logic [7:0] OFS_CORE  = 8'h34;
  localparam logic [7:0] OFS_EOI   = 8'h38;
  localparam logic [7:0] OFS_SPU   = 8'h3c;
  localparam logic [7:0] OFS_EN    = 8'h40;
  localparam logic [7:0] OFS_DIS   = 8'h44;
  localparam logic [7:0] OFS_CLR   = 8'h48;
  localparam logic [7:0] OFS_SET   = 8'h4c;
  localparam logic [7:0] OFS_FFEN  = 8'h50;
  localparam logic [7:0] OFS_FFDIS = 8'h54;
  localparam logic [7:0] OFS_FFST  = 8'h58;

endpackage

// File: rtl/isel_vic_bank.sv
module isel_vic_bank import isel_vic_pkg::*; #(
  parameter int N  = 128,
  parameter int PW = 3,
  parameter int VW = 32,
  parameter int SW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  src_i,
  input  logic [SW-1:0] sel_i,
  input  logic          mode_we_i,
  input  logic [PW-1:0] mode_prio_i,
  input  trig_e         mode_trig_i,
  input  logic          vec_we_i,
  input  logic [VW-1:0] vec_i,
  input  logic          en_set_i,
  input  logic          en_clr_i,
  input  logic          pend_set_i,
  input  logic          pend_clr_i,
  input  logic          ff_set_i,
  input  logic          ff_clr_i,
  input  logic          ack_i,
  input  logic [SW-1:0] ack_id_i,
  input  logic [SW-1:0] rd_id_i,
  output logic [N-1:0]  pend_o,
  output logic [N-1:0]  en_o,
  output logic [N-1:0]  ff_o,
  output logic [N*PW-1:0] prio_o,
  output logic [PW-1:0] sel_prio_o,
  output trig_e         sel_trig_o,
  output logic [VW-1:0] sel_vec_o,
  output logic [VW-1:0] rd_vec_o
);

  logic [VW-1:0] vec_mem [N];
  logic [N*2-1:0] trig_flat;

  // vector storage, no reset, single write port
  always_ff @(posedge clk) begin
    if (vec_we_i) vec_mem[sel_i] <= vec_i;
  end

  assign sel_vec_o  = vec_mem[sel_i];
  assign rd_vec_o   = vec_mem[rd_id_i];
  assign sel_prio_o = prio_o[sel_i*PW +: PW];
  assign sel_trig_o = trig_e'(trig_flat[sel_i*2 +: 2]);

  for (genvar i = 0; i < N; i++) begin : g_src
    logic          hit;
    logic          acked;
    trig_e         tq;
    logic [PW-1:0] pq;
    logic          lat, enq, ffq, sq;
    logic          edge_hit, lvl_act;

    assign hit   = (sel_i == SW'(i));
    assign acked = ack_i && (ack_id_i == SW'(i));

    always_comb begin
      edge_hit = 1'b0;
      unique case (tq)
        TRIG_RISE: edge_hit = src_i[i] & ~sq;
        TRIG_FALL: edge_hit = ~src_i[i] & sq;
        default:   edge_hit = 1'b0;
      endcase
      lvl_act = (tq == TRIG_LOW) ? ~src_i[i] : src_i[i];
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        tq <= TRIG_HIGH; pq <= '0; lat <= 1'b0;
        enq <= 1'b0; ffq <= 1'b0; sq <= 1'b0;
      end else begin
        sq <= src_i[i];
        if (hit && mode_we_i) begin
          tq <= mode_trig_i;
          pq <= mode_prio_i;
        end
        if (hit && en_set_i)      enq <= 1'b1;
        else if (hit && en_clr_i) enq <= 1'b0;
        if (hit && ff_set_i)      ffq <= 1'b1;
        else if (hit && ff_clr_i) ffq <= 1'b0;
        lat <= ((lat & ~acked) | edge_hit | (hit & pend_set_i))
               & ~(hit & pend_clr_i);
      end
    end

    // odd trigger codes are edge types
    assign pend_o[i] = lat | (~tq[0] & lvl_act);
    assign en_o[i]   = enq;
    assign ff_o[i]   = ffq;
    assign prio_o[i*PW +: PW]  = pq;
    assign trig_flat[i*2 +: 2] = tq;

    // R7
    edge_latch_chk: assert property (@(posedge clk) disable iff (rst)
      (tq[0] && !lat && !edge_hit && !(hit && pend_set_i)) |=> !lat);
  end

endmodule

// File: rtl/isel_vic_arb.sv
module isel_vic_arb #(
  parameter int N  = 128,
  parameter int PW = 3,
  parameter int SW = $clog2(N)
) (
  input  logic [N-1:0]    cand_i,
  input  logic [N*PW-1:0] prio_i,
  output logic            win_v_o,
  output logic [SW-1:0]   win_id_o,
  output logic [PW-1:0]   win_prio_o
);

  // scan from the top index down; >= lets a lower index take a tie
  always_comb begin
    win_v_o    = 1'b0;
    win_id_o   = '0;
    win_prio_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (cand_i[i] && (!win_v_o || prio_i[i*PW +: PW] >= win_prio_o)) begin
        win_v_o    = 1'b1;
        win_id_o   = SW'(i);
        win_prio_o = prio_i[i*PW +: PW];
      end
    end
  end

endmodule

// File: rtl/isel_vic_stack.sv
module isel_vic_stack #(
  parameter int DEPTH = 8,
  parameter int PW    = 3,
  parameter int SW    = 7,
  parameter int DW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push_i,
  input  logic [PW-1:0] push_prio_i,
  input  logic [SW-1:0] push_id_i,
  input  logic          pop_i,
  output logic [DW-1:0] depth_o,
  output logic [PW-1:0] top_prio_o,
  output logic [SW-1:0] top_id_o
);

  logic [PW-1:0] prio_st [DEPTH];
  logic [SW-1:0] id_st   [DEPTH];
  logic [DW-1:0] top_idx;

  assign top_idx = depth_o - DW'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      depth_o <= '0;
    end else if (push_i && depth_o < DW'(DEPTH)) begin
      depth_o <= depth_o + DW'(1);
    end else if (pop_i && depth_o != '0) begin
      depth_o <= depth_o - DW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (push_i && depth_o < DW'(DEPTH)) begin
      prio_st[depth_o[DW-2:0]] <= push_prio_i;
      id_st[depth_o[DW-2:0]]   <= push_id_i;
    end
  end

  assign top_prio_o = (depth_o != '0) ? prio_st[top_idx[DW-2:0]] : '0;
  assign top_id_o   = (depth_o != '0) ? id_st[top_idx[DW-2:0]]   : '0;

  // R8
  stack_no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    push_i |-> depth_o < DW'(DEPTH));

  // R8
  stack_push_top_chk: assert property (@(posedge clk) disable iff (rst)
    push_i |=> (top_prio_o == $past(push_prio_i) && top_id_o == $past(push_id_i)));

  // R9
  stack_pop_empty_chk: assert property (@(posedge clk) disable iff (rst)
    (pop_i && depth_o == '0) |=> depth_o == '0);

endmodule

// File: rtl/isel_vic.sv
module isel_vic import isel_vic_pkg::*; #(
  parameter int NSRC       = 128,
  parameter int PRIO_W     = 3,
  parameter int VEC_W      = 32,
  parameter int NEST_DEPTH = 8,
  parameter int ADDR_W     = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [NSRC-1:0]   src_i,
  output logic              irq_o,
  output logic              fiq_o
);

  localparam int SEL_W = $clog2(NSRC);
  localparam int NWORD = NSRC / 32;
  localparam int DEP_W = $clog2(NEST_DEPTH + 1);

  logic [SEL_W-1:0]  sel_q;
  logic [31:0]       spu_q;
  logic [NSRC-1:0]   pend_v, en_v, ff_v, route_v, live_v, cand_v;
  logic [NSRC*PRIO_W-1:0] prio_v;
  logic [PRIO_W-1:0] sel_prio, win_prio, top_prio;
  trig_e             sel_trig;
  logic [VEC_W-1:0]  sel_vec, win_vec;
  logic              win_v, take, may_take;
  logic [SEL_W-1:0]  win_id, top_id;
  logic [DEP_W-1:0]  depth;
  logic [31:0]       rd_mux, pend_word;

  function automatic logic wr_at(input logic [7:0] ofs);
    return bus_wr && (bus_addr == ADDR_W'(ofs));
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q <= '0;
      spu_q <= '0;
    end else begin
      if (wr_at(OFS_SEL)) sel_q <= bus_wdata[SEL_W-1:0];
      if (wr_at(OFS_SPU)) spu_q <= bus_wdata;
    end
  end

  isel_vic_bank #(.N(NSRC), .PW(PRIO_W), .VW(VEC_W), .SW(SEL_W)) u_bank (
    .clk(clk), .rst(rst), .src_i(src_i), .sel_i(sel_q),
    .mode_we_i(wr_at(OFS_MODE)), .mode_prio_i(bus_wdata[PRIO_W-1:0]),
    .mode_trig_i(trig_e'(bus_wdata[6:5])),
    .vec_we_i(wr_at(OFS_VEC)), .vec_i(bus_wdata[VEC_W-1:0]),
    .en_set_i(wr_at(OFS_EN) && bus_wdata[0]),
    .en_clr_i(wr_at(OFS_DIS) && bus_wdata[0]),
    .pend_set_i(wr_at(OFS_SET) && bus_wdata[0]),
    .pend_clr_i(wr_at(OFS_CLR) && bus_wdata[0]),
    .ff_set_i(wr_at(OFS_FFEN) && bus_wdata[0]),
    .ff_clr_i(wr_at(OFS_FFDIS) && bus_wdata[0]),
    .ack_i(take), .ack_id_i(win_id), .rd_id_i(win_id),
    .pend_o(pend_v), .en_o(en_v), .ff_o(ff_v), .prio_o(prio_v),
    .sel_prio_o(sel_prio), .sel_trig_o(sel_trig),
    .sel_vec_o(sel_vec), .rd_vec_o(win_vec)
  );

  // source 0 is hard-wired to the fast line
  assign route_v = ff_v | NSRC'(1);
  assign live_v  = pend_v & en_v;
  assign cand_v  = live_v & ~route_v;

  isel_vic_arb #(.N(NSRC), .PW(PRIO_W), .SW(SEL_W)) u_arb (
    .cand_i(cand_v), .prio_i(prio_v),
    .win_v_o(win_v), .win_id_o(win_id), .win_prio_o(win_prio)
  );

  assign may_take = win_v && (depth == '0 || win_prio > top_prio);
  assign take     = bus_rd && (bus_addr == ADDR_W'(OFS_IVR)) && may_take
                    && (depth < DEP_W'(NEST_DEPTH));

  isel_vic_stack #(.DEPTH(NEST_DEPTH), .PW(PRIO_W), .SW(SEL_W), .DW(DEP_W)) u_stack (
    .clk(clk), .rst(rst), .push_i(take), .push_prio_i(win_prio),
    .push_id_i(win_id), .pop_i(wr_at(OFS_EOI)),
    .depth_o(depth), .top_prio_o(top_prio), .top_id_o(top_id)
  );

  always_comb begin
    pend_word = '0;
    for (int k = 0; k < NWORD; k++) begin
      if (bus_addr[3:2] == 2'(k)) pend_word = pend_v[k*32 +: 32];
    end
  end

  always_comb begin
    rd_mux = '0;
    if (bus_addr[ADDR_W-1:4] == (ADDR_W-4)'(OFS_PEND_HI)) begin
      rd_mux = pend_word;
    end else begin
      unique case (bus_addr)
        ADDR_W'(OFS_SEL):  rd_mux = 32'(sel_q);
        ADDR_W'(OFS_MODE): rd_mux = 32'({sel_trig, 5'b0}) | 32'(sel_prio);
        ADDR_W'(OFS_VEC):  rd_mux = 32'(sel_vec);
        ADDR_W'(OFS_IVR):  rd_mux = take ? 32'(win_vec) : spu_q;
        ADDR_W'(OFS_ISR):  rd_mux = (depth != '0) ? 32'(top_id) : 32'd0;
        ADDR_W'(OFS_MASK): rd_mux = 32'(en_v[sel_q]);
        ADDR_W'(OFS_CORE): rd_mux = {30'd0, irq_o, fiq_o};
        ADDR_W'(OFS_SPU):  rd_mux = spu_q;
        ADDR_W'(OFS_FFST): rd_mux = 32'(ff_v[sel_q]);
        default:           rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      irq_o     <= 1'b0;
      fiq_o     <= 1'b0;
    end else begin
      if (bus_rd) bus_rdata <= rd_mux;
      irq_o <= may_take;
      fiq_o <= |(live_v & route_v);
    end
  end

  // R8
  irq_strict_chk: assert property (@(posedge clk) disable iff (rst)
    (depth != '0 && top_prio == '1) |=> !irq_o);

  // R4
  spurious_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == ADDR_W'(OFS_IVR) && !win_v) |=> bus_rdata == $past(spu_q));

  // R9
  isr_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == ADDR_W'(OFS_ISR) && depth == '0) |=> bus_rdata == 32'd0);

  // R10
  fiq_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    ((live_v & route_v) == '0) |=> !fiq_o);

endmodule

// File: tb/isel_vic_tb.sv
`timescale 1ns/1ps
module isel_vic_tb;

  localparam logic [7:0] A_SEL = 8'h00, A_MODE = 8'h04, A_VEC = 8'h08, A_IVR = 8'h10,
    A_ISR = 8'h18, A_P0 = 8'h20, A_P1 = 8'h24, A_P2 = 8'h28, A_P3 = 8'h2c,
    A_MASK = 8'h30, A_CORE = 8'h34, A_EOI = 8'h38, A_SPU = 8'h3c, A_EN = 8'h40,
    A_DIS = 8'h44, A_CLR = 8'h48, A_SET = 8'h4c, A_FFEN = 8'h50, A_FFDIS = 8'h54,
    A_FFST = 8'h58;
  localparam logic [31:0] SPUR = 32'hDEAD;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [127:0] src = '0;
  logic irq_o, fiq_o;
  logic rd_d = 1'b0;

  int checks = 0;
  int failures = 0;
  logic [31:0] exp_q[$];
  string tag_q[$];

  always #4 clk = ~clk;

  isel_vic u_dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .src_i(src),
    .irq_o(irq_o), .fiq_o(fiq_o)
  );

  always @(posedge clk) rd_d <= bus_rd;

  // monitor: pop one expected item per completed read
  always @(negedge clk) begin
    if (rd_d) begin
      checks++;
      if (exp_q.size() == 0) begin
        failures++;
        $display("FAIL scoreboard empty: actual %h expected none", bus_rdata);
      end else begin
        automatic logic [31:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        if (bus_rdata !== e) begin
          failures++;
          $display("FAIL %s: actual %h expected %h", t, bus_rdata, e);
        end
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] e, input string t);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk); bus_rd = 1'b0;
  endtask

  task automatic pin(input logic got, input logic e, input string t);
    checks++;
    if (got !== e) begin
      failures++;
      $display("FAIL %s: actual %b expected %b", t, got, e);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cfg(input int s, input logic [1:0] ty, input logic [2:0] p,
                     input logic [31:0] v);
    wr(A_SEL, 32'(s));
    wr(A_MODE, {25'd0, ty, 2'b0, p});
    wr(A_VEC, v);
    wr(A_EN, 32'd1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    idle(2);

    // R12 reset state
    pin(irq_o, 1'b0, "R12 irq after reset");
    pin(fiq_o, 1'b0, "R12 fiq after reset");
    rd(A_CORE, 32'd0, "R11 core status idle");
    rd(A_ISR, 32'd0, "R9 isr empty at reset");
    rd(A_P0, 32'd0, "R12 pend0 reset"); rd(A_P3, 32'd0, "R12 pend3 reset");
    rd(A_MASK, 32'd0, "R6 mask reset");

    // R4 spurious
    wr(A_SPU, SPUR);
    rd(A_IVR, SPUR, "R4 spurious when idle");

    // R1 R2 R3 select, mode, vector
    wr(A_SEL, 32'd5);
    wr(A_MODE, 32'h64);
    wr(A_VEC, 32'h500);
    rd(A_SEL, 32'd5, "R1 select readback");
    rd(A_MODE, 32'h64, "R2 mode readback");
    rd(A_VEC, 32'h500, "R3 vector readback");
    wr(A_SEL, 32'h85);
    rd(A_SEL, 32'd5, "R1 select keeps low 7 bits");
    wr(A_SEL, 32'd6);
    rd(A_MODE, 32'h40, "R1 other source untouched, R2 reset type");
    wr(A_SEL, 32'd5);
    wr(A_EN, 32'd1);
    rd(A_MASK, 32'd1, "R6 enable sets mask bit");

    // R7 rising edge latch
    src[5] = 1'b1; idle(3);
    rd(A_P0, 32'h20, "R7 edge latched");
    pin(irq_o, 1'b1, "R8 irq with empty stack");
    rd(A_CORE, 32'd2, "R11 core irq bit");
    src[5] = 1'b0; idle(2);
    rd(A_P0, 32'h20, "R7 edge latch holds");
    rd(A_IVR, 32'h500, "R4 vector of winner");
    idle(2);
    rd(A_P0, 32'd0, "R7 edge cleared by vector read");
    rd(A_ISR, 32'd5, "R9 isr shows top");
    pin(irq_o, 1'b0, "R8 irq drops after push");

    // R8 nesting with level sources
    cfg(40, 2'd2, 3'd6, 32'h4000);
    cfg(41, 2'd2, 3'd3, 32'h4100);
    src[40] = 1'b1; src[41] = 1'b1; idle(2);
    pin(irq_o, 1'b1, "R8 higher priority nests");
    rd(A_IVR, 32'h4000, "R5 higher priority wins");
    idle(2);
    pin(irq_o, 1'b0, "R8 equal or lower priority blocked");
    rd(A_ISR, 32'd40, "R9 isr nested");
    rd(A_P1, 32'h300, "R7 level follows input");
    src[40] = 1'b0; idle(2);
    rd(A_P1, 32'h200, "R7 level drop");
    wr(A_EOI, 32'd0);
    rd(A_ISR, 32'd5, "R9 pop returns to outer");
    pin(irq_o, 1'b0, "R8 prio 3 below top 4");
    wr(A_EOI, 32'd0);
    rd(A_ISR, 32'd0, "R9 stack empty");
    idle(2);
    pin(irq_o, 1'b1, "R8 irq with empty stack again");
    rd(A_IVR, 32'h4100, "R4 lower source taken");
    wr(A_EOI, 32'd0);
    src[41] = 1'b0;
    wr(A_SEL, 32'd41); wr(A_DIS, 32'd1);
    rd(A_MASK, 32'd0, "R6 disable clears mask");

    // R5 ties and R6 set
    cfg(71, 2'd3, 3'd2, 32'h71);
    cfg(70, 2'd3, 3'd2, 32'h70);
    wr(A_SET, 32'd1);
    wr(A_SEL, 32'd71); wr(A_SET, 32'd1);
    rd(A_P2, 32'hC0, "R6 set command pending");
    rd(A_IVR, 32'h70, "R5 tie to lowest index");
    rd(A_IVR, SPUR, "R8 equal priority cannot nest");
    wr(A_EOI, 32'd0);
    rd(A_IVR, 32'h71, "R5 second of tie");
    wr(A_EOI, 32'd0);
    rd(A_P2, 32'd0, "R7 both acked");

    cfg(100, 2'd3, 3'd1, 32'h100); wr(A_SET, 32'd1);
    cfg(120, 2'd3, 3'd5, 32'h120); wr(A_SET, 32'd1);
    rd(A_IVR, 32'h120, "R5 priority beats index");
    rd(A_IVR, SPUR, "R8 lower priority waits");
    wr(A_EOI, 32'd0);
    rd(A_IVR, 32'h100, "R5 remaining source");
    wr(A_EOI, 32'd0);
    wr(A_SEL, 32'd100); wr(A_SET, 32'd1);
    rd(A_P3, 32'h10, "R6 set on selected only");
    wr(A_CLR, 32'd1);
    rd(A_P3, 32'd0, "R6 clear command");

    // R2 falling edge and low level
    cfg(127, 2'd1, 3'd7, 32'h127);
    src[127] = 1'b1; idle(2);
    rd(A_P3, 32'd0, "R2 falling ignores rising");
    src[127] = 1'b0; idle(2);
    rd(A_P3, 32'h8000_0000, "R2 falling latched in top word");
    rd(A_IVR, 32'h127, "R4 top source vector");
    rd(A_ISR, 32'd127, "R9 isr top source");
    wr(A_EOI, 32'd0);
    wr(A_SEL, 32'd3); wr(A_MODE, 32'd0);
    idle(1);
    rd(A_P0, 32'h8, "R2 low level pending");
    pin(irq_o, 1'b0, "R6 disabled source no irq");
    src[3] = 1'b1; idle(1);
    rd(A_P0, 32'd0, "R2 low level released");

    // R10 fast line
    wr(A_SEL, 32'd0); wr(A_EN, 32'd1);
    src[0] = 1'b1; idle(2);
    pin(fiq_o, 1'b1, "R10 source 0 on fiq");
    pin(irq_o, 1'b0, "R10 source 0 not on irq");
    rd(A_CORE, 32'd1, "R11 core fiq bit");
    src[0] = 1'b0; idle(2);
    pin(fiq_o, 1'b0, "R10 fiq released");
    cfg(9, 2'd2, 3'd7, 32'h9);
    wr(A_FFEN, 32'd1);
    rd(A_FFST, 32'd1, "R10 fast status set");
    src[9] = 1'b1; idle(2);
    pin(fiq_o, 1'b1, "R10 forced source on fiq");
    pin(irq_o, 1'b0, "R10 forced source off irq");
    rd(A_IVR, SPUR, "R10 forced source not arbitrated");
    wr(A_FFDIS, 32'd1);
    rd(A_FFST, 32'd0, "R10 fast status cleared");
    idle(1);
    pin(irq_o, 1'b1, "R10 source back on irq");
    pin(fiq_o, 1'b0, "R10 fiq off after disable");
    rd(A_IVR, 32'h9, "R4 vector after unforce");
    src[9] = 1'b0;
    wr(A_EOI, 32'd0);

    // R9 full nest and unwind
    for (int k = 0; k < 8; k++) begin
      cfg(10 + k, 2'd3, 3'(k), 32'h200 + 32'(k));
      wr(A_SET, 32'd1);
      rd(A_IVR, 32'h200 + 32'(k), "R8 nest level push");
    end
    rd(A_ISR, 32'd17, "R9 full stack top");
    idle(2);
    pin(irq_o, 1'b0, "R8 full stack quiet");
    for (int k = 0; k < 4; k++) wr(A_EOI, 32'd0);
    rd(A_ISR, 32'd13, "R9 half unwound");
    for (int k = 0; k < 4; k++) wr(A_EOI, 32'd0);
    rd(A_ISR, 32'd0, "R9 eight pops unwind");
    wr(A_EOI, 32'd0);
    rd(A_ISR, 32'd0, "R9 pop on empty stack");

    idle(4);
    if (exp_q.size() != 0) begin
      failures++;
      $display("FAIL scoreboard leftover: actual %0d expected 0", exp_q.size());
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule